// File: doc/BRIEF.md
# Radio Configuration SPI Sequencer

This block brings up a sub-GHz FSK transmitter chip over SPI once a start pulse arrives. It drives the chip select, clock and data-out pins as an SPI master and plays a fixed bring-up script held in an internal ROM. The script mixes three kinds of transaction: one-byte command strobes, two-byte register writes (address byte, then data byte) and a single burst write that loads the eight-entry power table.

Before any transaction is clocked, the block lowers chip select and waits for the chip to pull MISO low, which signals that it is ready. If that does not happen within a programmable number of cycles, the run stops and an error flag is raised. The script ends with the transmit strobe, followed by a second write of both pin-function registers. A one-cycle done pulse then hands the radio over to the serial data path.

Top module: `radio_cfg_sequencer`

## Requirements
- R1: Out of reset, cs_n is 1, sclk is 0, and busy, done and ready_err are all 0.
- R2: A start pulse while idle begins a run. The first frame is the single reset command byte 0x30.
- R3: Frames follow in this fixed order. Each frame is bytes sent MSB first within one low period of cs_n. Register writes are address then data: 0x01=0x0B, 0x02=0x0C, 0x04=0xD3, 0x05=0x91, 0x06=0xFF, 0x08=0x12, 0x0A=0x00, 0x0D=0x21, 0x0E=0x65, 0x0F=0x6A, 0x10=0x87, 0x11=0xF8.
- R4: Next comes one 9-byte frame. Its header is the power-table address 0x3E plus the burst flag 0x40, giving 0x7E. The header is followed by the table bytes 0x03, 0x0E, 0x1D, 0x34, 0x60, 0x84, 0xC8, 0xC0.
- R5: The last three frames are the transmit strobe 0x35, then 0x01=0x0B, then 0x02=0x0C. A run is 17 frames in total.
- R6: After cs_n falls, sclk stays low while MISO is high. A frame is clocked even when MISO first reads low after READY_TIMEOUT-1 high cycles.
- R7: If MISO stays high for READY_TIMEOUT consecutive cycles, the run aborts. cs_n returns to 1, ready_err is set, busy clears and done does not pulse. ready_err holds until the next start.
- R8: SPI mode 0. sclk idles low, each high phase lasts HALF_DIV clock cycles, each low phase lasts at least HALF_DIV cycles, and mosi never changes while sclk is high.
- R9: Between consecutive frames of a run, cs_n stays high for at least two sclk periods (4*HALF_DIV cycles).
- R10: done pulses for exactly one cycle when the last frame ends. In that same cycle busy is 0 and cs_n is 1.
- R11: A start pulse while busy is ignored, and the run continues with its frame order intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the bring-up script |
| miso | input | 1 | SPI data from the chip; low means ready |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when the script has completed |
| ready_err | output | 1 | Set when the chip-ready wait timed out |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | SPI data to the chip, MSB first |
| cs_n | output | 1 | Active-low chip select, one assertion per frame |

## Verification
The bench builds the block with HALF_DIV=2 and READY_TIMEOUT=20. This keeps a full 39-byte run near two thousand cycles, so several complete runs fit, each with a different random ready delay on every frame. The short timeout puts both sides of the ready boundary within easy reach: a delay of 19 cycles still completes the run, and a delay of 20 aborts it in mid-script. With HALF_DIV=2, the bench can also measure every sclk phase and every chip-select gap exactly.

// File: rtl/radio_cfg_pkg.sv
package radio_cfg_pkg;

    // Command strobes and register addresses decoded by the radio chip
    localparam logic [7:0] CMD_RESET     = 8'h30;
    localparam logic [7:0] CMD_TX        = 8'h35;
    localparam logic [7:0] BURST_FLAG    = 8'h40;
    localparam logic [7:0] REG_PIN_B     = 8'h01;
    localparam logic [7:0] REG_PIN_A     = 8'h02;
    localparam logic [7:0] REG_SYNC_HI   = 8'h04;
    localparam logic [7:0] REG_SYNC_LO   = 8'h05;
    localparam logic [7:0] REG_PKT_LEN   = 8'h06;
    localparam logic [7:0] REG_PKT_CTRL  = 8'h08;
    localparam logic [7:0] REG_CHAN      = 8'h0A;
    localparam logic [7:0] REG_FREQ_HI   = 8'h0D;
    localparam logic [7:0] REG_FREQ_MID  = 8'h0E;
    localparam logic [7:0] REG_FREQ_LO   = 8'h0F;
    localparam logic [7:0] REG_RATE_EXP  = 8'h10;
    localparam logic [7:0] REG_RATE_MAN  = 8'h11;
    localparam logic [7:0] REG_PWR_TABLE = 8'h3E;

    localparam int SCRIPT_LEN = 39;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SHIFT,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       eof;   // last byte of its chip-select frame
    } step_t;

    function automatic step_t script_step(input int unsigned idx);
        step_t s;
        case (idx)
            0:  s = '{CMD_RESET,    1'b1};
            1:  s = '{REG_PIN_B,    1'b0};
            2:  s = '{8'h0B,        1'b1};
            3:  s = '{REG_PIN_A,    1'b0};
            4:  s = '{8'h0C,        1'b1};
            5:  s = '{REG_SYNC_HI,  1'b0};
            6:  s = '{8'hD3,        1'b1};
            7:  s = '{REG_SYNC_LO,  1'b0};
            8:  s = '{8'h91,        1'b1};
            9:  s = '{REG_PKT_LEN,  1'b0};
            10: s = '{8'hFF,        1'b1};
            11: s = '{REG_PKT_CTRL, 1'b0};
            12: s = '{8'h12,        1'b1};
            13: s = '{REG_CHAN,     1'b0};
            14: s = '{8'h00,        1'b1};
            15: s = '{REG_FREQ_HI,  1'b0};
            16: s = '{8'h21,        1'b1};
            17: s = '{REG_FREQ_MID, 1'b0};
            18: s = '{8'h65,        1'b1};
            19: s = '{REG_FREQ_LO,  1'b0};
            20: s = '{8'h6A,        1'b1};
            21: s = '{REG_RATE_EXP, 1'b0};
            22: s = '{8'h87,        1'b1};
            23: s = '{REG_RATE_MAN, 1'b0};
            24: s = '{8'hF8,        1'b1};
            25: s = '{REG_PWR_TABLE | BURST_FLAG, 1'b0};
            26: s = '{8'h03,        1'b0};
            27: s = '{8'h0E,        1'b0};
            28: s = '{8'h1D,        1'b0};
            29: s = '{8'h34,        1'b0};
            30: s = '{8'h60,        1'b0};
            31: s = '{8'h84,        1'b0};
            32: s = '{8'hC8,        1'b0};
            33: s = '{8'hC0,        1'b1};
            34: s = '{CMD_TX,       1'b1};
            35: s = '{REG_PIN_B,    1'b0};
            36: s = '{8'h0B,        1'b1};
            37: s = '{REG_PIN_A,    1'b0};
            38: s = '{8'h0C,        1'b1};
            default: s = '{8'h00,   1'b1};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/radio_cfg_rom.sv
module radio_cfg_rom
    import radio_cfg_pkg::*;
#(
    parameter int IDX_W = $clog2(SCRIPT_LEN)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       data,
    output logic             eof,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCRIPT_LEN - 1);

    step_t step;

    always_comb begin
        step = script_step(int'(idx));
        data = step.data;
        eof  = step.eof;
        last = (idx == LAST_IDX);
    end
endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] din,
    output logic       sclk,
    output logic       mosi,
    output logic       done
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic [DIV_W-1:0] div;
        logic [2:0]       bits;
        logic [7:0]       sh;
        logic             done;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (go && !eng_q.active) begin
            eng_d.active = 1'b1;
            eng_d.sclk   = 1'b0;
            eng_d.div    = '0;
            eng_d.bits   = '0;
            eng_d.sh     = din;
        end else if (eng_q.active) begin
            if (eng_q.div == DIV_LAST) begin
                eng_d.div = '0;
                if (!eng_q.sclk) begin
                    eng_d.sclk = 1'b1;           // chip samples on this rise
                end else begin
                    eng_d.sclk = 1'b0;
                    if (eng_q.bits == 3'd7) begin
                        eng_d.active = 1'b0;
                        eng_d.done   = 1'b1;
                    end else begin
                        eng_d.bits = eng_q.bits + 3'd1;
                        eng_d.sh   = {eng_q.sh[6:0], 1'b0};
                    end
                end
            end else begin
                eng_d.div = eng_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign sclk = eng_q.sclk;
    assign mosi = eng_q.sh[7];
    assign done = eng_q.done;

    // Data must hold steady for the whole high phase
    assert_mosi_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // Clock never rises outside an active byte
    assert_sclk_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(eng_q.active));
endmodule

// File: rtl/radio_cfg_sequencer.sv
module radio_cfg_sequencer
    import radio_cfg_pkg::*;
#(
    parameter int HALF_DIV      = 4,
    parameter int READY_TIMEOUT = 1000,
    parameter int GAP_SCLKS     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic miso,
    output logic busy,
    output logic done,
    output logic ready_err,
    output logic sclk,
    output logic mosi,
    output logic cs_n
);
    localparam int IDX_W   = $clog2(SCRIPT_LEN);
    localparam int GAP_CYC = 2 * HALF_DIV * GAP_SCLKS;
    localparam int CNT_MAX = (READY_TIMEOUT > GAP_CYC) ? READY_TIMEOUT : GAP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(READY_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             load;
        logic             cs_n;
        logic             done;
        logic             err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [7:0] rom_data;
    logic       rom_eof;
    logic       rom_last;
    logic       eng_go;
    logic       eng_done;

    radio_cfg_rom #(.IDX_W(IDX_W)) i_rom (
        .idx  (seq_q.idx),
        .data (rom_data),
        .eof  (rom_eof),
        .last (rom_last)
    );

    spi_byte_tx #(.HALF_DIV(HALF_DIV)) i_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (eng_go),
        .din   (rom_data),
        .sclk  (sclk),
        .mosi  (mosi),
        .done  (eng_done)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        eng_go     = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.state = ST_WAIT;
                    seq_d.idx   = '0;
                    seq_d.cnt   = '0;
                    seq_d.cs_n  = 1'b0;
                    seq_d.err   = 1'b0;
                end
            end
            ST_WAIT: begin
                if (!miso) begin
                    seq_d.state = ST_SHIFT;
                    seq_d.load  = 1'b1;
                end else if (seq_q.cnt == TO_LAST) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cs_n  = 1'b1;
                    seq_d.err   = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (seq_q.load) begin
                    eng_go     = 1'b1;
                    seq_d.load = 1'b0;
                end else if (eng_done) begin
                    if (!rom_eof) begin
                        seq_d.idx  = seq_q.idx + 1'b1;   // burst continues
                        seq_d.load = 1'b1;
                    end else begin
                        seq_d.cs_n = 1'b1;
                        seq_d.cnt  = '0;
                        if (rom_last) begin
                            seq_d.state = ST_IDLE;
                            seq_d.done  = 1'b1;
                        end else begin
                            seq_d.state = ST_GAP;
                            seq_d.idx   = seq_q.idx + 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (seq_q.cnt == GAP_LAST) begin
                    seq_d.state = ST_WAIT;
                    seq_d.cnt   = '0;
                    seq_d.cs_n  = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
            seq_q.cs_n  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.state != ST_IDLE);
    assign done      = seq_q.done;
    assign ready_err = seq_q.err;
    assign cs_n      = seq_q.cs_n;

    // Checker: consecutive cycles with chip select high, saturating
    logic [CNT_W-1:0] gap_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 gap_run_q <= '0;
        else if (!cs_n)             gap_run_q <= '0;
        else if (gap_run_q != GAP_LAST + 1'b1) gap_run_q <= gap_run_q + 1'b1;
    end

    assert_sclk_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    assert_no_clock_before_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_WAIT) |-> !sclk);

    assert_frame_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && seq_q.idx != '0) |-> (gap_run_q > GAP_LAST));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n));

    assert_abort_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_err) |-> (cs_n && !busy && !done));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (seq_q.idx >= $past(seq_q.idx)));
endmodule

// File: tb/test_radio_cfg_sequencer.sv
module test_radio_cfg_sequencer;
    localparam int HALF = 2;
    localparam int TMO  = 20;
    localparam int GAP  = 4 * HALF;
    localparam int NFR  = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic miso = 1'b1;
    logic busy, done, ready_err, sclk, mosi, cs_n;

    radio_cfg_sequencer #(.HALF_DIV(HALF), .READY_TIMEOUT(TMO)) i_radio_cfg_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .miso(miso),
        .busy(busy), .done(done), .ready_err(ready_err),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pwr_entry(input int i);
        logic [7:0] t [8] = '{8'h03, 8'h0E, 8'h1D, 8'h34, 8'h60, 8'h84, 8'hC8, 8'hC0};
        return t[i];
    endfunction

    function automatic int exp_len(input int f);
        if (f == 0 || f == 14) return 1;
        if (f == 13) return 9;
        return 2;
    endfunction

    function automatic logic [7:0] exp_byte(input int f, input int b);
        logic [7:0] adr [17] = '{8'h30, 8'h01, 8'h02, 8'h04, 8'h05, 8'h06, 8'h08, 8'h0A,
                                 8'h0D, 8'h0E, 8'h0F, 8'h10, 8'h11, 8'h00, 8'h35, 8'h01, 8'h02};
        logic [7:0] val [17] = '{8'h00, 8'h0B, 8'h0C, 8'hD3, 8'h91, 8'hFF, 8'h12, 8'h00,
                                 8'h21, 8'h65, 8'h6A, 8'h87, 8'hF8, 8'h00, 8'h00, 8'h0B, 8'h0C};
        if (f == 13) return (b == 0) ? (8'h3E | 8'h40) : pwr_entry(b - 1);
        return (b == 0) ? adr[f] : val[f];
    endfunction

    // Chip model and bus monitor, sampled on the falling clock edge
    int unsigned dly [32];
    logic [7:0]  rec [32][9];
    int          rec_len [32];
    int          nframes = 0;
    int          done_cnt = 0;
    int          hold = 0;
    int          hi_cnt = 0, lo_cnt = 0, gap_cnt = 0, cur_len = 0, bitcnt = 0;
    logic        prev_sclk = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
    logic [7:0]  shreg = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && prev_cs) begin
                if (gap_cnt < GAP) check("R9 cs_n gap", gap_cnt, GAP);
                cur_len = 0; bitcnt = 0;
                hold = int'(dly[nframes]);
            end
            if (cs_n && !prev_cs) begin
                rec_len[nframes] = cur_len;
                if (nframes < 31) nframes++;
            end
            gap_cnt = cs_n ? gap_cnt + 1 : 0;
            if (sclk && !prev_sclk) begin
                if (cs_n) check("R8 sclk outside frame", 1, 0);
                if (miso) check("R6 clock before ready", 1, 0);
                if (lo_cnt < HALF) check("R8 low phase", lo_cnt, HALF);
                shreg = {shreg[6:0], mosi};
                bitcnt++;
                if (bitcnt == 8) begin
                    if (cur_len < 9) rec[nframes][cur_len] = shreg;
                    cur_len++; bitcnt = 0;
                end
            end
            if (!sclk && prev_sclk) check("R8 high phase", hi_cnt, HALF);
            if (sclk && prev_sclk && mosi != prev_mosi) check("R8 mosi moved while high", 1, 0);
            hi_cnt = sclk ? hi_cnt + 1 : 0;
            lo_cnt = sclk ? 0 : lo_cnt + 1;
            if (done) begin
                done_cnt++;
                check("R10 busy/cs at done", {31'd0, busy} | ({31'd0, !cs_n} << 1), 0);
            end
            // chip ready model
            if (cs_n) miso = 1'b1;
            else if (hold > 0) begin miso = 1'b1; hold--; end
            else miso = 1'b0;
            prev_sclk = sclk; prev_cs = cs_n; prev_mosi = mosi;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end(output int cyc);
        cyc = 0;
        @(negedge clk);
        while (busy && cyc < 20000) begin @(negedge clk); cyc++; end
        repeat (12) @(negedge clk);
    endtask

    task automatic check_script(input string tag);
        check({tag, " R5 frame count"}, nframes, NFR);
        for (int f = 0; f < NFR; f++) begin
            string r = (f == 0) ? "R2" : (f == 13) ? "R4" : (f >= 14) ? "R5" : "R3";
            check({tag, " ", r, " frame length"}, rec_len[f], exp_len(f));
            for (int b = 0; b < exp_len(f) && b < rec_len[f]; b++)
                check({tag, " ", r, " frame byte"}, int'(rec[f][b]), int'(exp_byte(f, b)));
        end
    endtask

    task automatic run_ok(input string tag, input int mode, input bit mid_start);
        int cyc;
        int d0;
        for (int i = 0; i < 32; i++) begin
            dly[i] = (mode == 0) ? $urandom % 13 : (mode == 1) ? 0 : TMO - 1;
        end
        nframes = 0; d0 = done_cnt;
        pulse_start();
        check({tag, " R7 err cleared by start"}, int'(ready_err), 0);
        if (mid_start) begin
            repeat (300) @(negedge clk);
            check({tag, " R11 busy before extra start"}, int'(busy), 1);
            pulse_start();
        end
        wait_end(cyc);
        check({tag, " R10 done pulses"}, done_cnt - d0, 1);
        check({tag, " R7 no error"}, int'(ready_err), 0);
        check({tag, " R10 idle after run"}, int'(busy), 0);
        check_script(tag);
    endtask

    initial begin
        int cyc;
        int d0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check("R1 cs_n in reset", int'(cs_n), 1);
        check("R1 sclk in reset", int'(sclk), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 ready_err", int'(ready_err), 0);
        check("R1 cs_n", int'(cs_n), 1);

        run_ok("rand0", 0, 1'b0);
        run_ok("zero", 1, 1'b0);
        run_ok("edge19 R6", 2, 1'b0);
        run_ok("rand1 R11", 0, 1'b1);

        // Timeout abort on frame 4
        for (int i = 0; i < 32; i++) dly[i] = 0;
        dly[4] = TMO;
        nframes = 0; d0 = done_cnt;
        pulse_start();
        wait_end(cyc);
        check("R7 ready_err set", int'(ready_err), 1);
        check("R7 busy cleared", int'(busy), 0);
        check("R7 cs_n released", int'(cs_n), 1);
        check("R7 no done", done_cnt - d0, 0);
        check("R7 frames reached", nframes, 5);
        check("R7 aborted frame empty", rec_len[4], 0);
        check("R3 frames before abort", int'(rec[3][0]), 8'h04);

        run_ok("rand2", 0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule